// File: doc/BRIEF.md
# Conditional Branch Decision Unit

This unit resolves relative branches. Each cycle it may accept one request. A request carries a 4-bit condition selector, the four arithmetic flags (negative, zero, two's complement overflow and carry/borrow) and the sequential program counter. It also carries an 8-bit signed displacement. The unit decides whether the branch is taken and produces the program counter to fetch from next. On a taken branch that is the sequential address plus the sign-extended displacement. Otherwise it is the sequential address itself.

The conditions include an unconditional branch and its never-taken partner. They cover each single-flag test in both polarities. They also cover the unsigned and signed magnitude comparisons that follow a subtraction. Every selector value pairs with the one that differs only in bit 0, and the two always decide oppositely. The decision and target are combinational and are captured into output registers, so results appear one clock after the request.

Top module: `branchDecider`

## Requirements
- R1: While rstN is low, outValid, taken and pcNext are all zero.
- R2: A request presented with inValid high at a rising edge produces outValid high after that edge, carrying its result. outValid is low after any edge where inValid was low, and every request yields exactly one result.
- R3: Selector 0 (always) is taken whatever the flags are; selector 1 (never) is never taken.
- R4: Selectors 2/3 test C=0/C=1 and also serve as unsigned higher-or-same/lower. Selectors 4/5 test Z=0/Z=1. Selectors 6/7 test N=0/N=1. Selectors 8/9 test V=0/V=1.
- R5: Selector 10 (unsigned higher) is taken when (C OR Z)=0; selector 11 (unsigned lower-or-same) is taken when (C OR Z)=1.
- R6: Selector 12 (signed greater-or-equal) is taken when (N XOR V)=0; selector 13 (signed less) is taken when (N XOR V)=1.
- R7: Selector 14 (signed greater) is taken when (Z OR (N XOR V))=0; selector 15 (signed less-or-equal) is taken when (Z OR (N XOR V))=1.
- R8: For any flag values, two selectors that differ only in bit 0 give opposite decisions.
- R9: When taken, pcNext equals pcSeq plus the displacement sign-extended from bit 7, modulo 2^16. When not taken, pcNext equals pcSeq.
- R10: After an edge where inValid is low, taken and pcNext keep their previous values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | A branch request is present this cycle |
| condCode | input | 4 | Condition selector, encoding per R3 to R7 |
| flagN | input | 1 | Negative flag |
| flagZ | input | 1 | Zero flag |
| flagV | input | 1 | Two's complement overflow flag |
| flagC | input | 1 | Carry / borrow flag |
| pcSeq | input | 16 | Address of the next sequential instruction |
| offset | input | 8 | Signed branch displacement |
| outValid | output | 1 | Result registers hold a fresh decision |
| taken | output | 1 | Branch decision of the last request |
| pcNext | output | 16 | Next program counter of the last request |

## Verification
The assertions relate each registered result to the request sampled one edge earlier. They assume that the inputs are stable and known at the rising edge while inValid is high. They also assume that a cycle counts only when reset was released at the previous edge. The bench changes inputs only on the falling edge and holds inValid low throughout reset. It also scrambles selector, flags, address and displacement during idle cycles, so that the hold property is tested against moving inputs, not against quiet ones.

// File: rtl/brPkg.sv
package brPkg;

  // Pair index = condCode[3:1]; bit 0 selects the "raw" (odd) or inverted (even) member.
  localparam logic [2:0] PAIR_ALWAYS  = 3'd0;  // 0 always, 1 never
  localparam logic [2:0] PAIR_CARRY   = 3'd1;  // 2 C clear, 3 C set
  localparam logic [2:0] PAIR_ZERO    = 3'd2;  // 4 Z clear, 5 Z set
  localparam logic [2:0] PAIR_NEG     = 3'd3;  // 6 N clear, 7 N set
  localparam logic [2:0] PAIR_OVF     = 3'd4;  // 8 V clear, 9 V set
  localparam logic [2:0] PAIR_UMAG    = 3'd5;  // 10 higher, 11 lower-or-same
  localparam logic [2:0] PAIR_SLT     = 3'd6;  // 12 ge, 13 lt
  localparam logic [2:0] PAIR_SLE     = 3'd7;  // 14 gt, 15 le

  typedef struct packed {
    logic capture;  // load the result registers
    logic takeBr;   // decision for the current request
  } ctrlStrobeT;

endpackage

// File: rtl/condEval.sv
module condEval
  import brPkg::*;
(
  input  logic       inValid,
  input  logic [3:0] condCode,
  input  logic       flagN,
  input  logic       flagZ,
  input  logic       flagV,
  input  logic       flagC,
  output ctrlStrobeT strobe
);

  logic signedLess;
  logic rawCond;

  assign signedLess = flagN ^ flagV;

  // Raw value is the decision of the odd member of each pair.
  always_comb begin
    unique case (condCode[3:1])
      PAIR_ALWAYS: rawCond = 1'b0;
      PAIR_CARRY:  rawCond = flagC;
      PAIR_ZERO:   rawCond = flagZ;
      PAIR_NEG:    rawCond = flagN;
      PAIR_OVF:    rawCond = flagV;
      PAIR_UMAG:   rawCond = flagC | flagZ;
      PAIR_SLT:    rawCond = signedLess;
      PAIR_SLE:    rawCond = flagZ | signedLess;
      default:     rawCond = 1'b0;
    endcase
  end

  always_comb begin
    strobe.capture = inValid;
    strobe.takeBr  = condCode[0] ? rawCond : ~rawCond;
  end

endmodule

// File: rtl/pcDatapath.sv
module pcDatapath
  import brPkg::*;
#(
  parameter int PC_W  = 16,
  parameter int OFF_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobeT       strobe,
  input  logic [PC_W-1:0]  pcSeq,
  input  logic [OFF_W-1:0] offset,
  output logic             outValid,
  output logic             taken,
  output logic [PC_W-1:0]  pcNext
);

  localparam int EXT_W = (PC_W > OFF_W) ? (PC_W - OFF_W) : 1;

  logic [PC_W-1:0] offsetExt;
  logic [PC_W-1:0] branchTarget;
  logic [PC_W-1:0] pcChosen;

  generate
    if (PC_W > OFF_W) begin : g_ext
      assign offsetExt = {{EXT_W{offset[OFF_W-1]}}, offset};
    end else begin : g_trunc
      assign offsetExt = offset[PC_W-1:0];
    end
  endgenerate

  assign branchTarget = pcSeq + offsetExt;
  assign pcChosen     = strobe.takeBr ? branchTarget : pcSeq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      taken    <= 1'b0;
      pcNext   <= '0;
    end else begin
      outValid <= strobe.capture;
      if (strobe.capture) begin
        taken  <= strobe.takeBr;
        pcNext <= pcChosen;
      end
    end
  end

endmodule

// File: rtl/branchDecider.sv
module branchDecider
  import brPkg::*;
#(
  parameter int PC_W  = 16,
  parameter int OFF_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [3:0]       condCode,
  input  logic             flagN,
  input  logic             flagZ,
  input  logic             flagV,
  input  logic             flagC,
  input  logic [PC_W-1:0]  pcSeq,
  input  logic [OFF_W-1:0] offset,
  output logic             outValid,
  output logic             taken,
  output logic [PC_W-1:0]  pcNext
);

  ctrlStrobeT strobe;

  condEval i_ctrl (
    .inValid (inValid),
    .condCode(condCode),
    .flagN   (flagN),
    .flagZ   (flagZ),
    .flagV   (flagV),
    .flagC   (flagC),
    .strobe  (strobe)
  );

  pcDatapath #(.PC_W(PC_W), .OFF_W(OFF_W)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .pcSeq   (pcSeq),
    .offset  (offset),
    .outValid(outValid),
    .taken   (taken),
    .pcNext  (pcNext)
  );

endmodule

// File: rtl/branchDeciderChecker.sv
module branchDeciderChecker #(
  parameter int PC_W  = 16,
  parameter int OFF_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [3:0]       condCode,
  input logic             flagN,
  input logic             flagZ,
  input logic             flagV,
  input logic             flagC,
  input logic [PC_W-1:0]  pcSeq,
  input logic [OFF_W-1:0] offset,
  input logic             outValid,
  input logic             taken,
  input logic [PC_W-1:0]  pcNext
);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> outValid == $past(inValid)); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(inValid)) |-> ($stable(taken) && $stable(pcNext))); // R10

  AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(inValid) && $past(condCode) == 4'd0) |-> taken); // R3

  AST_NEVER_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(inValid) && $past(condCode) == 4'd1) |-> !taken); // R3

  AST_ZERO_SET: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(inValid) && $past(condCode) == 4'd5) |-> taken == $past(flagZ)); // R4

  AST_UNSIGNED_HIGHER: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(inValid) && $past(condCode) == 4'd10)
      |-> taken == !($past(flagC) || $past(flagZ))); // R5

  AST_SIGNED_LESS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(inValid) && $past(condCode) == 4'd13)
      |-> taken == ($past(flagN) ^ $past(flagV))); // R6

  AST_SIGNED_LEQ: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(inValid) && $past(condCode) == 4'd15)
      |-> taken == ($past(flagZ) || ($past(flagN) ^ $past(flagV)))); // R7

  AST_SEQ_WHEN_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(inValid) && !taken) |-> pcNext == $past(pcSeq)); // R9

  AST_TARGET_WHEN_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(inValid) && taken)
      |-> pcNext == $past(pcSeq) + PC_W'($signed($past(offset)))); // R9

endmodule

bind branchDecider branchDeciderChecker #(.PC_W(PC_W), .OFF_W(OFF_W)) i_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .condCode(condCode),
  .flagN(flagN), .flagZ(flagZ), .flagV(flagV), .flagC(flagC),
  .pcSeq(pcSeq), .offset(offset), .outValid(outValid),
  .taken(taken), .pcNext(pcNext)
);

// File: tb/test_branchDecider.sv
module test_branchDecider;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [3:0]  condCode = '0;
  logic        flagN = 1'b0, flagZ = 1'b0, flagV = 1'b0, flagC = 1'b0;
  logic [15:0] pcSeq = '0;
  logic [7:0]  offset = '0;
  logic        outValid;
  logic        taken;
  logic [15:0] pcNext;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic        tk;
    logic [15:0] pc;
    string       req;
  } expItemT;

  expItemT expQ[$];

  always #10 clk = ~clk;  // 50 MHz

  branchDecider i_branchDecider (
    .clk(clk), .rstN(rstN), .inValid(inValid), .condCode(condCode),
    .flagN(flagN), .flagZ(flagZ), .flagV(flagV), .flagC(flagC),
    .pcSeq(pcSeq), .offset(offset), .outValid(outValid),
    .taken(taken), .pcNext(pcNext)
  );

  // Reference decision, written per selector from the requirements.
  function automatic logic refTaken(logic [3:0] c, logic n, logic z, logic v, logic cy);
    case (c)
      4'd0:  return 1'b1;            // R3
      4'd1:  return 1'b0;            // R3
      4'd2:  return !cy;             // R4
      4'd3:  return cy;              // R4
      4'd4:  return !z;              // R4
      4'd5:  return z;               // R4
      4'd6:  return !n;              // R4
      4'd7:  return n;               // R4
      4'd8:  return !v;              // R4
      4'd9:  return v;               // R4
      4'd10: return !(cy || z);      // R5
      4'd11: return cy || z;         // R5
      4'd12: return !(n ^ v);        // R6
      4'd13: return n ^ v;           // R6
      4'd14: return !(z || (n ^ v)); // R7
      default: return z || (n ^ v);  // R7
    endcase
  endfunction

  function automatic string reqOf(logic [3:0] c);
    if (c < 4'd2)       return "R3";
    else if (c < 4'd10) return "R4";
    else if (c < 4'd12) return "R5";
    else if (c < 4'd14) return "R6";
    else                return "R7";
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic pushExp(logic tk, logic [15:0] pcs, logic [7:0] off, string req);
    expItemT it;
    it.tk  = tk;
    it.pc  = tk ? (pcs + {{8{off[7]}}, off}) : pcs;  // R9
    it.req = req;
    expQ.push_back(it);
  endtask

  task automatic drive(logic [3:0] c, logic [3:0] f, logic [15:0] pcs, logic [7:0] off, string req);
    @(negedge clk);
    inValid  = 1'b1;
    condCode = c;
    {flagN, flagZ, flagV, flagC} = f;
    pcSeq    = pcs;
    offset   = off;
    pushExp(refTaken(c, f[3], f[2], f[1], f[0]), pcs, off, req);
  endtask

  task automatic idle(int cycles);
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      inValid  = 1'b0;
      condCode = 4'(k * 5 + 3);
      {flagN, flagZ, flagV, flagC} = 4'(k * 7 + 1);
      pcSeq    = 16'(16'hBEEF + k * 97);
      offset   = 8'(k * 29 + 3);
    end
  endtask

  // Monitor / scoreboard: sample between the rising and falling edges.
  initial begin
    logic        lastTk;
    logic [15:0] lastPc;
    bit          armed;
    expItemT     it;
    lastTk = 1'b0;
    lastPc = '0;
    armed  = 1'b0;
    forever begin
      @(posedge clk);
      #5;
      if (!rstN) begin
        armed = 1'b0;
      end else if (!armed) begin
        armed = 1'b1;
        lastTk = taken;
        lastPc = pcNext;
        if (outValid) begin
          check("R2", "outValid at reset release", 32'(outValid), 32'd0);
        end
      end else if (outValid) begin
        if (expQ.size() == 0) begin
          check("R2", "result without request", 32'd1, 32'd0);
        end else begin
          it = expQ.pop_front();
          check(it.req, "taken", 32'(taken), 32'(it.tk));
          check("R9", "pcNext", 32'(pcNext), 32'(it.pc));
        end
        lastTk = taken;
        lastPc = pcNext;
      end else begin
        check("R10", "taken held", 32'(taken), 32'(lastTk));
        check("R10", "pcNext held", 32'(pcNext), 32'(lastPc));
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL R2 watchdog expired actual=%0d pending expected=0", expQ.size());
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "outValid in reset", 32'(outValid), 32'd0);
    check("R1", "taken in reset", 32'(taken), 32'd0);
    check("R1", "pcNext in reset", 32'(pcNext), 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    idle(2);

    // Exhaustive selector x flag sweep with varying address and displacement.
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        drive(4'(c), 4'(f), 16'(16'h1000 + (c * 16 + f) * 3), 8'(c * 37 + f * 11), reqOf(4'(c)));
        if (f == 7) idle(2);  // R10 with scrambled inputs
      end
    end

    // R8: complementary pairs back to back under the same flags.
    for (int p = 0; p < 8; p++) begin
      for (int f = 0; f < 16; f += 5) begin
        drive(4'(2 * p), 4'(f), 16'h2222, 8'h10, "R8");
        drive(4'(2 * p + 1), 4'(f), 16'h2222, 8'h10, "R8");
      end
    end

    // R9 boundaries: max forward, max backward, wrap in both directions.
    drive(4'd0, 4'h0, 16'hFFF0, 8'h7F, "R9");  // wraps forward to 0x006F
    drive(4'd0, 4'h0, 16'h0005, 8'h80, "R9");  // wraps backward to 0xFF85
    drive(4'd0, 4'h0, 16'h4000, 8'hFF, "R9");  // minus one
    drive(4'd0, 4'h0, 16'h4000, 8'h00, "R9");  // zero displacement
    drive(4'd1, 4'h0, 16'hFFFF, 8'h7F, "R9");  // not taken keeps sequential
    idle(3);

    // R2: back-to-back requests then drain.
    for (int k = 0; k < 6; k++) drive(4'd5, 4'(k), 16'(16'h3000 + k), 8'(k), "R2");
    idle(4);
    check("R2", "unanswered requests", 32'(expQ.size()), 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule